// File: doc/BRIEF.md
# Constant-Off-Time Current Limit Controller

This block sits beside the low-side switch of one half-bridge and decides, clock by clock, whether that switch may conduct. When the output is asked to drive, the block opens a blanking window. Inside that window the current-limit comparator is not looked at. Only the short-circuit comparator can act there, and if it fires the block latches the bridge into a high-impedance state and reports a short. The report stays set until the fault logic clears it.

Once blanking has ended, a current-limit trip turns the switch off and requests a tri-state for a fixed off time. Drive then comes back with a fresh blanking window. The off time is computed at elaboration from the clock rate. It is stretched when needed so that the self-generated switching rate cannot exceed a set maximum.

A second part turns a junction-temperature code into a digital current-limit threshold code. The code holds at its nominal value up to a knee temperature and then falls linearly. Above the shutdown temperature it raises an overtemperature flag, and that flag removes drive.

Top module: `cot_limit_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, gate_en, tristate_req, short_det and overtemp are 0 and ilim_code equals the nominal code (65 at default).
- R2: When drive_req rises with no fault present, gate_en is 1 from the next cycle. It stays 1 for BLANK_CYC+1 cycles even if ilim_flag is held high: BLANK_CYC blanking cycles, with BLANK_CYC = CLK_KHZ*BLANK_NS/1000000 (165 at default), plus one sampling cycle.
- R3: An ilim_flag seen after blanking makes gate_en 0 and tristate_req 1 from the next cycle, for exactly OFF_CYC cycles. If drive_req is still 1, gate_en then returns with a new blanking window.
- R4: OFF_CYC = max(CLK_KHZ*OFF_NS/1000000, CLK_KHZ/MAX_SW_KHZ - BLANK_CYC - 1), which is 334 at default. With ilim_flag held high, one whole on-plus-off period is therefore never shorter than CLK_KHZ/MAX_SW_KHZ cycles (500 at default).
- R5: short_flag seen in any blanking cycle, the last one included, sets short_det to 1, gate_en to 0 and tristate_req to 1 from the next cycle. These hold regardless of the other inputs until a short_clr pulse. The cycle after that pulse, the block is idle.
- R6: short_flag has no effect outside blanking. One cycle after blanking ends, or during normal drive, short_det stays 0 and gate_en stays 1.
- R7: Dropping drive_req during drive makes gate_en 0 and tristate_req 0 from the next cycle. Dropping it during an off time does not shorten the off time: tristate_req stays 1 for the full OFF_CYC cycles, and then the block is idle.
- R8: One cycle after tj_code is applied, ilim_code shows the folded threshold. For tj at or below T_KNEE (160) the code is NOM_CODE (65). For T_KNEE < tj <= T_SHUT (175) it is NOM_CODE - floor((tj-T_KNEE)*(NOM_CODE-FOLD_CODE)/(T_SHUT-T_KNEE)), with FOLD_CODE = 40.
- R9: For tj above T_SHUT, one cycle later overtemp is 1, ilim_code is FOLD_CODE, gate_en is 0 and tristate_req is 1.
- R10: short_clr has no effect when no short is latched. During drive, gate_en stays 1 and tristate_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| drive_req | input | 1 | Request for the low-side switch to conduct; its rise is an output activation |
| ilim_flag | input | 1 | Current-limit comparator result |
| short_flag | input | 1 | Short-circuit comparator result |
| short_clr | input | 1 | Synchronous clear of a latched short, from the fault logic |
| tj_code | input | TJ_W (8) | Junction temperature in whole degrees C, unsigned |
| gate_en | output | 1 | Qualifier that allows the low-side gate to be driven |
| tristate_req | output | 1 | Request to hold the bridge output in high impedance |
| short_det | output | 1 | Latched hard-short report |
| ilim_code | output | CODE_W (7) | Current-limit threshold in 0.1 A steps |
| overtemp | output | 1 | Junction temperature above the shutdown point |

## Verification
First, a limit flag held high through a whole activation is applied. The measured run lengths of gate_en and tristate_req then separate the blanking length, the stretched off time and the full switching period. A short inserted at random blanking cycles, at the last blanking cycle and at the first cycle after blanking separates a latching short from one that is ignored. Dropping drive during an off time and during normal drive separates a timed release from an immediate one. Random and boundary temperature codes around the knee and the shutdown point separate the flat part, the linear foldback and the shutdown region.

// File: rtl/cot_pkg.sv
package cot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BLANK = 3'd1,
    ST_RUN   = 3'd2,
    ST_OFF   = 3'd3,
    ST_LATCH = 3'd4
  } cot_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cot_timer.sv
module cot_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = load | dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // a loaded interval starts from the loaded value
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/cot_fold.sv
module cot_fold #(
  parameter int TJ_W      = 8,
  parameter int CODE_W    = 7,
  parameter int NOM_CODE  = 65,
  parameter int FOLD_CODE = 40,
  parameter int T_KNEE    = 160,
  parameter int T_SHUT    = 175
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TJ_W-1:0]   tj_code,
  output logic [CODE_W-1:0] ilim_code,
  output logic              overtemp
);

  localparam int PW   = TJ_W + CODE_W;
  localparam int DROP = NOM_CODE - FOLD_CODE;
  localparam int SPAN = T_SHUT - T_KNEE;

  logic [TJ_W-1:0]   dtj;
  logic [PW-1:0]     prod;
  logic [PW-1:0]     quo;
  logic [CODE_W-1:0] code_d;
  logic              ot_d;

  assign dtj  = tj_code - TJ_W'(T_KNEE);
  assign prod = PW'(dtj) * PW'(DROP);
  assign quo  = prod / PW'(SPAN);

  always_comb begin
    ot_d   = 1'b0;
    code_d = CODE_W'(NOM_CODE);
    if (tj_code > TJ_W'(T_SHUT)) begin
      ot_d   = 1'b1;
      code_d = CODE_W'(FOLD_CODE);
    end else if (tj_code > TJ_W'(T_KNEE)) begin
      code_d = CODE_W'(NOM_CODE) - CODE_W'(quo);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilim_code <= CODE_W'(NOM_CODE);
      overtemp  <= 1'b0;
    end else begin
      ilim_code <= code_d;
      overtemp  <= ot_d;
    end
  end

  assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_code <= CODE_W'(NOM_CODE)) && (ilim_code >= CODE_W'(FOLD_CODE)));

  assert_hot_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tj_code > TJ_W'(T_SHUT)) |=> overtemp);

  assert_flag_floor_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |-> (ilim_code == CODE_W'(FOLD_CODE)));

endmodule

// File: rtl/cot_seq.sv
module cot_seq
  import cot_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int BLANK_CYC = 165,
  parameter int OFF_CYC   = 334,
  parameter int MIN_PER   = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_req,
  input  logic             ilim_flag,
  input  logic             short_flag,
  input  logic             short_clr,
  input  logic             overtemp,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_dec,
  output logic             gate_en,
  output logic             tristate_req,
  output logic             short_det
);

  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LD   = CNT_W'(OFF_CYC - 1);
  localparam int               PER_W    = $clog2(MIN_PER + 1) + 1;

  cot_state_e st_q;
  cot_state_e st_d;
  logic       drive_eff;
  logic       load_blank;
  logic       load_off;

  assign drive_eff = drive_req & ~overtemp;

  always_comb begin
    st_d       = st_q;
    load_blank = 1'b0;
    load_off   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (drive_eff) begin
          st_d       = ST_BLANK;
          load_blank = 1'b1;
        end
      end
      ST_BLANK: begin
        if (short_flag) begin
          st_d = ST_LATCH;
        end else if (!drive_eff) begin
          st_d = ST_IDLE;
        end else if (tmr_zero) begin
          st_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!drive_eff) begin
          st_d = ST_IDLE;
        end else if (ilim_flag) begin
          st_d     = ST_OFF;
          load_off = 1'b1;
        end
      end
      ST_OFF: begin
        if (tmr_zero) begin
          if (drive_eff) begin
            st_d       = ST_BLANK;
            load_blank = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_LATCH: begin
        if (short_clr) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign tmr_load = load_blank | load_off;
  assign tmr_val  = load_off ? OFF_LD : BLANK_LD;
  assign tmr_dec  = ((st_q == ST_BLANK) || (st_q == ST_OFF)) && !tmr_zero;

  assign gate_en      = ((st_q == ST_BLANK) || (st_q == ST_RUN)) && !overtemp;
  assign tristate_req = (st_q == ST_OFF) || (st_q == ST_LATCH) || overtemp;
  assign short_det    = (st_q == ST_LATCH);

  // checker state: length of the current off interval and spacing of off entries
  logic [CNT_W-1:0] chk_off_q;
  logic [PER_W-1:0] chk_per_q;
  logic             chk_seen_q;
  logic             off_entry;

  assign off_entry = (st_q != ST_OFF) && (st_d == ST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_off_q  <= '0;
      chk_per_q  <= '0;
      chk_seen_q <= 1'b0;
    end else begin
      chk_off_q <= (st_q == ST_OFF) ? chk_off_q + 1'b1 : '0;
      if (off_entry) begin
        chk_per_q  <= '0;
        chk_seen_q <= 1'b1;
      end else if (chk_per_q != '1) begin
        chk_per_q <= chk_per_q + 1'b1;
      end
    end
  end

  assert_off_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_OFF) && (st_d != ST_OFF)) |-> (chk_off_q == OFF_LD));

  assert_period_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_entry && chk_seen_q) |-> ((int'(chk_per_q) + 1) >= MIN_PER));

  assert_blank_no_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_BLANK) && !short_flag) |=> (st_q != ST_OFF));

  assert_short_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_det) |-> $past((st_q == ST_BLANK) && short_flag));

  assert_short_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_det && !short_clr) |=> short_det);

  assert_run_short_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && drive_eff && !ilim_flag) |=> (gate_en || overtemp));

endmodule

// File: rtl/cot_limit_ctrl.sv
module cot_limit_ctrl
  import cot_pkg::*;
#(
  parameter int CLK_KHZ    = 10000,
  parameter int OFF_NS     = 20000,
  parameter int BLANK_NS   = 16500,
  parameter int MAX_SW_KHZ = 20,
  parameter int TJ_W       = 8,
  parameter int CODE_W     = 7,
  parameter int NOM_CODE   = 65,
  parameter int FOLD_CODE  = 40,
  parameter int T_KNEE     = 160,
  parameter int T_SHUT     = 175
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_req,
  input  logic              ilim_flag,
  input  logic              short_flag,
  input  logic              short_clr,
  input  logic [TJ_W-1:0]   tj_code,
  output logic              gate_en,
  output logic              tristate_req,
  output logic              short_det,
  output logic [CODE_W-1:0] ilim_code,
  output logic              overtemp
);

  localparam int BLANK_CYC = CLK_KHZ * BLANK_NS / 1000000;
  localparam int OFF_NOM   = CLK_KHZ * OFF_NS / 1000000;
  localparam int MIN_PER   = CLK_KHZ / MAX_SW_KHZ;
  localparam int OFF_CYC   = imax(OFF_NOM, MIN_PER - BLANK_CYC - 1);
  localparam int CNT_W     = $clog2(imax(OFF_CYC, BLANK_CYC) + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_dec;
  logic             tmr_zero;

  cot_fold #(
    .TJ_W      (TJ_W),
    .CODE_W    (CODE_W),
    .NOM_CODE  (NOM_CODE),
    .FOLD_CODE (FOLD_CODE),
    .T_KNEE    (T_KNEE),
    .T_SHUT    (T_SHUT)
  ) u_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .tj_code   (tj_code),
    .ilim_code (ilim_code),
    .overtemp  (overtemp)
  );

  cot_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  cot_seq #(
    .CNT_W     (CNT_W),
    .BLANK_CYC (BLANK_CYC),
    .OFF_CYC   (OFF_CYC),
    .MIN_PER   (MIN_PER)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .drive_req    (drive_req),
    .ilim_flag    (ilim_flag),
    .short_flag   (short_flag),
    .short_clr    (short_clr),
    .overtemp     (overtemp),
    .tmr_zero     (tmr_zero),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .tmr_dec      (tmr_dec),
    .gate_en      (gate_en),
    .tristate_req (tristate_req),
    .short_det    (short_det)
  );

endmodule

// File: tb/tb_cot_limit_ctrl.sv
module tb_cot_limit_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_KHZ    = 10000;
  localparam int OFF_NS     = 20000;
  localparam int BLANK_NS   = 16500;
  localparam int MAX_SW_KHZ = 20;
  localparam int B_CYC      = CLK_KHZ * BLANK_NS / 1000000;
  localparam int OFF_NOM    = CLK_KHZ * OFF_NS / 1000000;
  localparam int MINP       = CLK_KHZ / MAX_SW_KHZ;
  localparam int OFF_CYC    = (OFF_NOM > MINP - B_CYC - 1) ? OFF_NOM : (MINP - B_CYC - 1);
  localparam int NOM        = 65;
  localparam int FOLD       = 40;
  localparam int KNEE       = 160;
  localparam int SHUT       = 175;

  logic       clk;
  logic       rst_n;
  logic       drive_req;
  logic       ilim_flag;
  logic       short_flag;
  logic       short_clr;
  logic [7:0] tj_code;
  logic       gate_en;
  logic       tristate_req;
  logic       short_det;
  logic [6:0] ilim_code;
  logic       overtemp;

  int n_chk;
  int n_bad;
  bit done;

  cot_limit_ctrl #(
    .CLK_KHZ    (CLK_KHZ),
    .OFF_NS     (OFF_NS),
    .BLANK_NS   (BLANK_NS),
    .MAX_SW_KHZ (MAX_SW_KHZ),
    .TJ_W       (8),
    .CODE_W     (7),
    .NOM_CODE   (NOM),
    .FOLD_CODE  (FOLD),
    .T_KNEE     (KNEE),
    .T_SHUT     (SHUT)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .drive_req    (drive_req),
    .ilim_flag    (ilim_flag),
    .short_flag   (short_flag),
    .short_clr    (short_clr),
    .tj_code      (tj_code),
    .gate_en      (gate_en),
    .tristate_req (tristate_req),
    .short_det    (short_det),
    .ilim_code    (ilim_code),
    .overtemp     (overtemp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int exp_code(input int t);
    if (t > SHUT) return FOLD;
    if (t > KNEE) return NOM - ((t - KNEE) * (NOM - FOLD)) / (SHUT - KNEE);
    return NOM;
  endfunction

  function automatic int exp_ot(input int t);
    return (t > SHUT) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic len_gate(input bit want, output int n);
    n = 0;
    while ((gate_en == want) && (n < 4000)) begin
      n++;
      step(1);
    end
  endtask

  task automatic len_tri(input bit want, output int n);
    n = 0;
    while ((tristate_req == want) && (n < 4000)) begin
      n++;
      step(1);
    end
  endtask

  task automatic go_idle();
    drive_req  = 1'b0;
    ilim_flag  = 1'b0;
    short_flag = 1'b0;
    step(OFF_CYC + 5);
    short_clr = 1'b1;
    step(1);
    short_clr = 1'b0;
    step(2);
  endtask

  // short raised at negedge j after activation (activation at negedge 0)
  task automatic blank_short(input int j);
    drive_req = 1'b1;
    step(j);
    short_flag = 1'b1;
    step(1);
    if (j <= B_CYC) begin
      chk(short_det == 1'b1, "R5 short latch", int'(short_det), 1);
      chk(gate_en == 1'b0 && tristate_req == 1'b1, "R5 latch tri-state",
          int'({gate_en, tristate_req}), 1);
    end else begin
      chk(short_det == 1'b0, "R6 short after blanking", int'(short_det), 0);
      chk(gate_en == 1'b1, "R6 gate kept", int'(gate_en), 1);
    end
  endtask

  initial begin
    int unsigned seed_init;
    int h1, l1, h2, t1;
    seed_init = $urandom(32'd20417);
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    drive_req = 1'b0;
    ilim_flag = 1'b0;
    short_flag = 1'b0;
    short_clr = 1'b0;
    tj_code = 8'd25;
    step(3);
    chk({gate_en, tristate_req, short_det, overtemp} == 4'b0000, "R1 reset outputs",
        int'({gate_en, tristate_req, short_det, overtemp}), 0);
    chk(ilim_code == 7'(NOM), "R1 reset code", int'(ilim_code), NOM);
    rst_n = 1'b1;
    step(1);
    chk({gate_en, tristate_req, short_det, overtemp} == 4'b0000, "R1 after release",
        int'({gate_en, tristate_req, short_det, overtemp}), 0);

    // limit flag held through activation
    ilim_flag = 1'b1;
    drive_req = 1'b1;
    step(1);
    len_gate(1'b1, h1);
    chk(h1 == B_CYC + 1, "R2 blanking ignores limit flag", h1, B_CYC + 1);
    chk(tristate_req == 1'b1, "R3 tri-state on trip", int'(tristate_req), 1);
    len_gate(1'b0, l1);
    chk(l1 == OFF_CYC, "R3 off time length", l1, OFF_CYC);
    len_gate(1'b1, h2);
    chk(h2 == B_CYC + 1, "R3 resume with new blanking", h2, B_CYC + 1);
    chk(h2 + l1 == MINP, "R4 switching period floor", h2 + l1, MINP);

    // drive dropped at first cycle of an off time
    drive_req = 1'b0;
    ilim_flag = 1'b0;
    len_tri(1'b1, t1);
    chk(t1 == OFF_CYC, "R7 off time not shortened", t1, OFF_CYC);
    chk(gate_en == 1'b0 && tristate_req == 1'b0, "R7 idle after off",
        int'({gate_en, tristate_req}), 0);

    // drive dropped during normal drive
    drive_req = 1'b1;
    step(B_CYC + 10);
    chk(gate_en == 1'b1, "R7 normal drive", int'(gate_en), 1);
    drive_req = 1'b0;
    step(1);
    chk(gate_en == 1'b0 && tristate_req == 1'b0, "R7 immediate release",
        int'({gate_en, tristate_req}), 0);
    step(3);

    // short at the last blanking cycle, then hold and clear
    blank_short(B_CYC);
    drive_req = 1'b0;
    short_flag = 1'b0;
    step(5);
    chk(short_det == 1'b1 && tristate_req == 1'b1, "R5 latch held",
        int'({short_det, tristate_req}), 3);
    short_clr = 1'b1;
    step(1);
    short_clr = 1'b0;
    chk({short_det, tristate_req, gate_en} == 3'b000, "R5 clear to idle",
        int'({short_det, tristate_req, gate_en}), 0);
    step(2);

    // short one cycle after blanking ends
    blank_short(B_CYC + 1);
    go_idle();

    // short during idle has no effect
    short_flag = 1'b1;
    step(4);
    chk(short_det == 1'b0 && gate_en == 1'b0, "R6 short while idle",
        int'({short_det, gate_en}), 0);
    short_flag = 1'b0;
    step(1);

    // short at random blanking cycles
    for (int i = 0; i < 4; i++) begin
      blank_short(1 + int'($urandom % B_CYC));
      go_idle();
    end
    blank_short(1);
    go_idle();

    // short in run state, then clear pulse with nothing latched
    drive_req = 1'b1;
    step(B_CYC + 10);
    short_flag = 1'b1;
    step(10);
    chk(gate_en == 1'b1 && short_det == 1'b0, "R6 short during drive",
        int'({gate_en, short_det}), 2);
    short_flag = 1'b0;
    short_clr = 1'b1;
    step(1);
    short_clr = 1'b0;
    step(1);
    chk(gate_en == 1'b1 && tristate_req == 1'b0 && short_det == 1'b0, "R10 clear ignored",
        int'({gate_en, tristate_req, short_det}), 4);

    // temperature foldback: directed boundaries then random codes
    for (int i = 0; i < 46; i++) begin
      int t;
      case (i)
        0: t = 0;
        1: t = 160;
        2: t = 161;
        3: t = 175;
        4: t = 176;
        5: t = 255;
        default: t = 150 + int'($urandom % 40);
      endcase
      tj_code = 8'(t);
      step(1);
      chk(int'(ilim_code) == exp_code(t), "R8 threshold code", int'(ilim_code), exp_code(t));
      chk(int'(overtemp) == exp_ot(t), "R9 overtemp flag", int'(overtemp), exp_ot(t));
      if (exp_ot(t) == 1) begin
        chk(gate_en == 1'b0 && tristate_req == 1'b1, "R9 drive removed",
            int'({gate_en, tristate_req}), 1);
      end
    end
    tj_code = 8'd25;
    step(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule